// File: doc/BRIEF.md
# Radix-4 Booth Partial-Product Generator

This block is the combinational front half of a 32 by 32 multiplier that accepts any mix of signed and unsigned operands. Each operand carries its own mode flag. Both operands are widened by one bit so that signed and unsigned values share one arithmetic form. The widened multiplier is then recoded into seventeen radix-4 Booth digits, each in the range -2 to +2.

For every digit the block forms one partial-product row from the widened multiplicand. The multiplicand is selected as is for a magnitude of one, shifted up by one place for a magnitude of two, or cleared for zero. A negative digit inverts the row bitwise. The +1 that completes the two's complement is not added into the row. Instead the block exports one negate bit per digit, and a downstream adder adds that bit at the row's base weight. Each row is sign-extended and placed at weight 4^i in a 64-bit lane, ready for a carry-save reduction tree.

Top module: `booth_ppgen`

## Requirements
- R1: When a mode flag is 0 (unsigned), that operand's 33rd bit is 0. An all-ones 32-bit operand is therefore taken as 2^32-1.
- R2: When a mode flag is 1 (signed), that operand's 33rd bit is a copy of its bit 31.
- R3: Digit i is recoded from the triplet {m[2i+1], m[2i], m[2i-1]} of the widened multiplier m, with m[-1]=0 and m[33]=m[32]. The triplets map to digits as follows: 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0.
- R4: pp_neg_o[i] is 1 exactly when digit i is negative (-1 or -2).
- R5: Row i holds the 34-bit value d·B for d ≥ 0. For d < 0 it holds the bitwise inverse of |d|·B, which equals d·B-1. B is the widened multiplicand. No +1 is added.
- R6: A zero digit (triplet 000 or 111) gives an all-zero row and leaves its negate bit at 0.
- R7: Row i is sign-extended from its bit 33 and shifted left by 2i within lane i of pp_rows_o, which covers bits 64i+63 down to 64i. Bits beyond 63 are dropped, and the low 2i bits of the lane are 0.
- R8: Modulo 2^64, the sum of all 17 lanes plus each pp_neg_o[i]·4^i equals the exact product of the two widened operands, for all four mode combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mplier_i | input | 32 | Multiplier operand (recoded) |
| mplier_signed_i | input | 1 | 1: multiplier is signed, 0: unsigned |
| mcand_i | input | 32 | Multiplicand operand (selected into rows) |
| mcand_signed_i | input | 1 | 1: multiplicand is signed, 0: unsigned |
| pp_rows_o | output | 1088 | 17 lanes of 64 bits; lane i at bits 64i+63:64i |
| pp_neg_o | output | 17 | Per-row negate bit, to be added at weight 4^i |

## Verification
The bench targets all-ones and most-negative operands in every mode pairing. There, a wrong 33rd bit turns a huge unsigned value into -1, and the product sum goes wrong by a multiple of 2^32. Alternating bit patterns drive every group to +1/-1, and double-bit patterns drive them to +2/-2. A select-two path that takes the wrong neighbour bit, or a triplet window off by one place, shows up as a wrong row in those lanes. Zero and all-ones multipliers produce zero digits in both triplet forms. A design that inverts on 111, or adds a correction bit for it, gives an all-ones row or a stray negate bit. Random operands compare the top lane, whose placement truncates above bit 63, against a behavioural digit-times-operand model.

// File: rtl/booth_pkg.sv
package booth_pkg;

    localparam int unsigned OP_W = 32;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } digit_t;

endpackage

// File: rtl/booth_extend.sv
module booth_extend #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_i,
    input  logic         signed_i,
    output logic [W:0]   ext_o
);

    logic top_d;

    always_comb begin
        top_d = signed_i & op_i[W-1];
        ext_o = {top_d, op_i};
    end

endmodule

// File: rtl/booth_recoder.sv
module booth_recoder (
    input  logic [2:0]        trip_i,
    output booth_pkg::digit_t dig_o
);

    always_comb begin
        dig_o = '0;
        unique case (trip_i)
            3'b001, 3'b010: dig_o.one = 1'b1;
            3'b011:         dig_o.two = 1'b1;
            3'b100: begin
                dig_o.two = 1'b1;
                dig_o.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                dig_o.one = 1'b1;
                dig_o.neg = 1'b1;
            end
            default:        dig_o = '0;
        endcase
    end

endmodule

// File: rtl/booth_row.sv
module booth_row #(
    parameter int unsigned EW = 33,
    localparam int unsigned RW = EW + 1
) (
    input  logic [EW-1:0]     b_i,
    input  booth_pkg::digit_t dig_i,
    output logic [RW-1:0]     row_o
);

    logic [RW-1:0] b_ext_d;
    logic [RW-1:0] b_dbl_d;

    always_comb begin
        b_ext_d = {b_i[EW-1], b_i};
        b_dbl_d = {b_i, 1'b0};
    end

    for (genvar j = 0; j < RW; j++) begin : g_bit
        always_comb begin
            row_o[j] = ((dig_i.one & b_ext_d[j]) | (dig_i.two & b_dbl_d[j])) ^ dig_i.neg;
        end
    end

    always_comb begin
        assert_sel_onehot_R3: assert ($onehot0({dig_i.one, dig_i.two}))
            else $error("both magnitude selects high");
        assert_neg_needs_sel_R4: assert (!dig_i.neg || dig_i.one || dig_i.two)
            else $error("negate set on a zero digit");
        assert_zero_row_R6: assert (dig_i.one || dig_i.two || row_o == '0)
            else $error("zero digit produced a nonzero row");
    end

endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen #(
    parameter int unsigned W = booth_pkg::OP_W,
    localparam int unsigned EW   = W + 1,
    localparam int unsigned PADW = EW + 2,
    localparam int unsigned NG   = (EW + 1) / 2,
    localparam int unsigned RW   = EW + 1,
    localparam int unsigned PW   = 2 * W
) (
    input  logic [W-1:0]     mplier_i,
    input  logic             mplier_signed_i,
    input  logic [W-1:0]     mcand_i,
    input  logic             mcand_signed_i,
    output logic [NG*PW-1:0] pp_rows_o,
    output logic [NG-1:0]    pp_neg_o
);

    logic [EW-1:0]   mplier_ext;
    logic [EW-1:0]   mcand_ext;
    logic [PADW-1:0] mplier_pad_d;

    booth_extend #(.W(W)) i_ext_mplier (
        .op_i     (mplier_i),
        .signed_i (mplier_signed_i),
        .ext_o    (mplier_ext)
    );

    booth_extend #(.W(W)) i_ext_mcand (
        .op_i     (mcand_i),
        .signed_i (mcand_signed_i),
        .ext_o    (mcand_ext)
    );

    always_comb begin
        mplier_pad_d = {mplier_ext[EW-1], mplier_ext, 1'b0};
    end

    always_comb begin
        assert_ext_unsigned_R1: assert (mplier_signed_i || !mplier_ext[EW-1])
            else $error("unsigned multiplier widened with a 1");
        assert_ext_signed_R2: assert (!mcand_signed_i || mcand_ext[EW-1] == mcand_i[W-1])
            else $error("signed multiplicand not sign-extended");
    end

    for (genvar i = 0; i < NG; i++) begin : g_grp
        localparam logic [PW-1:0] LOW_MASK = (PW'(1) << (2 * i)) - PW'(1);

        booth_pkg::digit_t dig;
        logic [RW-1:0]     row;
        logic [PW-1:0]     placed_d;

        booth_recoder i_rec (
            .trip_i (mplier_pad_d[2*i+2 -: 3]),
            .dig_o  (dig)
        );

        booth_row #(.EW(EW)) i_row (
            .b_i   (mcand_ext),
            .dig_i (dig),
            .row_o (row)
        );

        always_comb begin
            placed_d = {{(PW-RW){row[RW-1]}}, row} << (2 * i);
            pp_rows_o[i*PW +: PW] = placed_d;
            pp_neg_o[i] = dig.neg;
        end

        always_comb begin
            assert_row_aligned_R7: assert ((pp_rows_o[i*PW +: PW] & LOW_MASK) == '0)
                else $error("row %0d has bits below its weight", i);
        end
    end

endmodule

// File: tb/test_booth_ppgen.sv
module test_booth_ppgen;

    localparam int NG = 17;
    localparam int PW = 64;

    logic          clk = 1'b0;
    logic [31:0]   mplier;
    logic          mplier_s;
    logic [31:0]   mcand;
    logic          mcand_s;
    logic [NG*PW-1:0] rows;
    logic [NG-1:0] negs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    booth_ppgen i_booth_ppgen (
        .mplier_i        (mplier),
        .mplier_signed_i (mplier_s),
        .mcand_i         (mcand),
        .mcand_signed_i  (mcand_s),
        .pp_rows_o       (rows),
        .pp_neg_o        (negs)
    );

    function automatic longint widen(input logic [31:0] v, input logic s);
        if (s) return longint'($signed(v));
        return longint'({32'd0, v});
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (mplier %h/%0d mcand %h/%0d)",
                     tag, act, exp, mplier, mplier_s, mcand, mcand_s);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic as, input logic [31:0] b, input logic bs);
        longint av, bv, tv, d, er, sum;
        logic [63:0] lane;
        @(posedge clk);
        mplier = a; mplier_s = as; mcand = b; mcand_s = bs;
        @(negedge clk);
        av = widen(a, as);
        bv = widen(b, bs);
        sum = 0;
        for (int i = 0; i < NG; i++) begin
            tv = ((av <<< 1) >>> (2 * i)) & 64'sd7;
            d  = (tv & 1) + ((tv >> 1) & 1) - 2 * ((tv >> 2) & 1);
            er = (d * bv - ((d < 0) ? 64'sd1 : 64'sd0)) <<< (2 * i);
            lane = rows[i*PW +: PW];
            if (d == 0)
                check64("R6 zero row", lane, 64'd0);
            else
                check64("R3/R5/R7 row", lane, er);
            check64("R4 neg", {63'd0, negs[i]}, (d < 0) ? 64'd1 : 64'd0);
            sum = sum + longint'(lane) + (negs[i] ? (64'sd1 <<< (2 * i)) : 64'sd0);
        end
        if (!as || !bs)
            check64("R1/R8 unsigned product", sum, av * bv);
        else
            check64("R2/R8 signed product", sum, av * bv);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] edge_v [8];
        edge_v[0] = 32'h0000_0000; edge_v[1] = 32'hFFFF_FFFF;
        edge_v[2] = 32'h8000_0000; edge_v[3] = 32'h7FFF_FFFF;
        edge_v[4] = 32'h5555_5555; edge_v[5] = 32'hAAAA_AAAA;
        edge_v[6] = 32'h3333_3333; edge_v[7] = 32'hCCCC_CCCC;
        mplier = '0; mplier_s = 1'b0; mcand = '0; mcand_s = 1'b0;
        // all-zero inputs: every row and negate bit clear (R6)
        apply(32'd0, 1'b0, 32'd0, 1'b0);
        for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++)
                for (int m = 0; m < 4; m++)
                    apply(edge_v[x], m[0], edge_v[y], m[1]);
        for (int k = 0; k < 300; k++)
            apply($urandom, 1'($urandom), $urandom, 1'($urandom));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule